// File: doc/BRIEF.md
# Programmable 10-bit Colour Space Converter

This block converts a stream of pixels, each made of three 10-bit components, into three new 10-bit components. It is typically used to turn RGB into limited-range YCbCr, but every parameter can be reprogrammed. Each input component first receives a signed offset and is then held inside a programmable window. The three results then pass through a 3x3 signed fixed-point matrix. Each matrix output is rounded, receives a second signed offset, and is held inside a second window. Pixels move with a valid/ready handshake at one pixel per clock, through four register stages.

Parameters are written over a plain address/data port into a set of staging words. They reach the datapath only when a frame-start pulse copies the staging words into the working set, so a frame never mixes two parameter sets. Reads return the staging words. After reset both sets hold a limited-range RGB-to-YCbCr conversion. When the enable bit of the working set is clear, pixels leave the block exactly as they arrived, with the same latency.

Top module: `csc10_top`

## Requirements
- R1: After reset the staging words read back as follows. Word 0 = 0x00000001. Words 1..5 = 0x01020083, 0x1FB50032, 0x00E11F6C, 0x1F4500E1, 0x00001FDC. Words 6..8 = 0x000003FF. Word 9 = 0x004003AC. Words 10..11 = 0x004003C0. Words 12..14 = 0. Word 15 = 0x040. Words 16..17 = 0x200. With these settings a black pixel converts to (64, 512, 512) and a white pixel (1023 on all components) converts to (940, 516, 516).
- R2: Word n sits at byte address 4n, with n from 0 to 17. Coefficients are 13-bit two's complement, row-major c0..c8, with 0x200 meaning 1.0. Word 1+k holds c(2k) in bits 12:0 and c(2k+1) in bits 28:16. Word 5 holds c8 in bits 12:0. Clamp words 6..8 (pre) and 9..11 (post) hold, for components 0..2, the lower limit in bits 25:16 and the upper limit in bits 9:0. Bias words 12..14 (pre) and 15..17 (post) hold an 11-bit two's-complement offset in bits 10:0. Word 0 bit 0 is the enable. Bits outside these fields read as zero.
- R3: Each input component has its pre-offset added. The sum is limited to the pre-window and saturated, never wrapped.
- R4: Each output row is the full-precision sum of three products. The row value is (sum + 256) arithmetically shifted right by 9, so halves round upward, negative ones included.
- R5: Each rounded row value has its post-offset added and is then limited to the post-window. When the lower limit exceeds the upper limit, the result equals the lower limit.
- R6: When the enable bit is 0, the output pixel equals the input pixel bit for bit.
- R7: Writes change only the staging words. The datapath keeps its settings until a frame_start pulse copies the staging words into the working set.
- R8: A pixel accepted at a clock edge with no stall appears with out_valid high after the fourth edge, counting the accepting edge. out_valid stays low after the first three edges.
- R9: While out_valid is high and out_ready is low, in_ready is low and out_pix holds its value. Every accepted pixel leaves exactly once, in order.
- R10: cfg_rdata shows the word addressed one edge earlier. Word addresses above 17 read as zero, and writes to them change nothing.
- R11: While rst is high and on the edge after it, out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the staging word at cfg_addr |
| cfg_addr | input | 8 | Byte address of a parameter word |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered readback of the staging word |
| frame_start | input | 1 | Copies the staging words into the working set |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept a pixel |
| in_pix | input | 30 | Input components; component 0 in bits 9:0, component 1 in 19:10, component 2 in 29:20 |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the pixel |
| out_pix | output | 30 | Output components, same packing as in_pix |

## Verification
The bench aims at the saturation points. A white pixel drives the luma row past its upper limit, and a negative pre-offset pushes a component below zero. A design that truncated instead of saturating would wrap to large codes in both cases. Half-way products on both signs of zero catch a design that rounds toward zero or truncates. An inverted window catches a design that lets the upper limit win. Pixels sent after a write but before frame_start catch settings that leak into the datapath early. A long stream with irregular valid and ready gaps catches lost or repeated pixels, and bypass mode catches any bit being altered.

// File: rtl/csc10_pkg.sv
package csc10_pkg;
  localparam int PIX_W  = 10;
  localparam int COEF_W = 13;
  localparam int FRAC_W = 9;
  localparam int BIAS_W = 11;
  localparam int NCH    = 3;
  localparam int NCOEF  = NCH * NCH;
  localparam int NWORDS = 18;
  localparam int CFG_AW = 8;
  localparam int SUM_W  = PIX_W + 1 + COEF_W + 2;
  localparam int Y_W    = SUM_W - FRAC_W + 2;

  localparam int W_MODE   = 0;
  localparam int W_COEF   = 1;
  localparam int W_PRECL  = 6;
  localparam int W_POSTCL = 9;
  localparam int W_PREB   = 12;
  localparam int W_POSTB  = 15;

  typedef struct packed {
    logic                         en;
    logic [NCOEF-1:0][COEF_W-1:0] coef;
    logic [NCH-1:0][BIAS_W-1:0]   pre_bias;
    logic [NCH-1:0][BIAS_W-1:0]   post_bias;
    logic [NCH-1:0][PIX_W-1:0]    pre_lo;
    logic [NCH-1:0][PIX_W-1:0]    pre_hi;
    logic [NCH-1:0][PIX_W-1:0]    post_lo;
    logic [NCH-1:0][PIX_W-1:0]    post_hi;
  } csc_cfg_t;

  function automatic logic [31:0] word_mask(input int i);
    if (i == W_MODE) return 32'h0000_0001;
    if (i >= W_COEF && i < W_COEF + 4) return 32'h1FFF_1FFF;
    if (i == W_COEF + 4) return 32'h0000_1FFF;
    if (i >= W_PRECL && i < W_PREB) return 32'h03FF_03FF;
    return 32'h0000_07FF;
  endfunction

  function automatic logic [31:0] reset_word(input int i);
    case (i)
      0:       return 32'h0000_0001;
      1:       return 32'h0102_0083;
      2:       return 32'h1FB5_0032;
      3:       return 32'h00E1_1F6C;
      4:       return 32'h1F45_00E1;
      5:       return 32'h0000_1FDC;
      6, 7, 8: return 32'h0000_03FF;
      9:       return 32'h0040_03AC;
      10, 11:  return 32'h0040_03C0;
      15:      return 32'h0000_0040;
      16, 17:  return 32'h0000_0200;
      default: return 32'h0000_0000;
    endcase
  endfunction

  function automatic logic [PIX_W-1:0] clamp_win(input int x, input logic [PIX_W-1:0] lo,
                                                 input logic [PIX_W-1:0] hi);
    int t;
    t = x;
    if (t > int'(hi)) t = int'(hi);
    if (t < int'(lo)) t = int'(lo);
    return t[PIX_W-1:0];
  endfunction
endpackage

// File: rtl/csc10_regs.sv
module csc10_regs
  import csc10_pkg::*;
#(
  parameter int AW = CFG_AW,
  parameter int NW = NWORDS
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr,
  input  logic [AW-1:0]  addr,
  input  logic [31:0]    wdata,
  input  logic           frame_start,
  output logic [31:0]    rdata,
  output csc_cfg_t       cfg
);
  localparam int IDX_W = AW - 2;

  logic [31:0] sh_q  [NW];
  logic [31:0] act_q [NW];
  logic [31:0] rd_mux;
  logic [IDX_W-1:0] idx;

  assign idx = addr[AW-1:2];

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NW; i++)
      if (idx == IDX_W'(i)) rd_mux = sh_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NW; i++) begin
        sh_q[i]  <= reset_word(i);
        act_q[i] <= reset_word(i);
      end
      rdata <= '0;
    end else begin
      for (int i = 0; i < NW; i++) begin
        if (wr && idx == IDX_W'(i)) sh_q[i] <= wdata & word_mask(i);
        if (frame_start) act_q[i] <= sh_q[i];
      end
      rdata <= rd_mux;
    end
  end

  always_comb begin
    cfg.en = act_q[W_MODE][0];
    for (int k = 0; k < NCOEF; k++)
      cfg.coef[k] = act_q[W_COEF + k / 2][(k % 2) * 16 +: COEF_W];
    for (int c = 0; c < NCH; c++) begin
      cfg.pre_lo[c]    = act_q[W_PRECL + c][16 +: PIX_W];
      cfg.pre_hi[c]    = act_q[W_PRECL + c][0 +: PIX_W];
      cfg.post_lo[c]   = act_q[W_POSTCL + c][16 +: PIX_W];
      cfg.post_hi[c]   = act_q[W_POSTCL + c][0 +: PIX_W];
      cfg.pre_bias[c]  = act_q[W_PREB + c][0 +: BIAS_W];
      cfg.post_bias[c] = act_q[W_POSTB + c][0 +: BIAS_W];
    end
  end
endmodule

// File: rtl/csc10_bias_clamp.sv
module csc10_bias_clamp
  import csc10_pkg::*;
#(
  parameter int IN_W = PIX_W + 1,
  parameter int BW   = BIAS_W,
  parameter int OW   = PIX_W
) (
  input  logic                  clk,
  input  logic                  en,
  input  logic signed [IN_W-1:0] din,
  input  logic signed [BW-1:0]   bias,
  input  logic [OW-1:0]          lo,
  input  logic [OW-1:0]          hi,
  output logic [OW-1:0]          dout
);
  int sum;

  always_comb sum = int'(din) + int'(bias);

  always_ff @(posedge clk)
    if (en) dout <= clamp_win(sum, lo, hi);
endmodule

// File: rtl/csc10_matrix.sv
module csc10_matrix
  import csc10_pkg::*;
(
  input  logic                         clk,
  input  logic                         en,
  input  logic [NCH-1:0][PIX_W-1:0]    a,
  input  logic [NCOEF-1:0][COEF_W-1:0] coef,
  output logic [NCH-1:0][SUM_W-1:0]    sum_q
);
  logic [NCH-1:0][SUM_W-1:0] sum_d;

  always_comb begin
    for (int r = 0; r < NCH; r++) begin
      int acc;
      acc = 0;
      for (int j = 0; j < NCH; j++)
        acc = acc + int'({1'b0, a[j]}) * int'($signed(coef[r * NCH + j]));
      sum_d[r] = acc[SUM_W-1:0];
    end
  end

  always_ff @(posedge clk)
    if (en) sum_q <= sum_d;
endmodule

// File: rtl/csc10_post.sv
module csc10_post
  import csc10_pkg::*;
(
  input  logic                       clk,
  input  logic                       en,
  input  logic [NCH-1:0][SUM_W-1:0]  sum,
  input  logic [NCH-1:0][BIAS_W-1:0] bias,
  input  logic [NCH-1:0][PIX_W-1:0]  lo,
  input  logic [NCH-1:0][PIX_W-1:0]  hi,
  input  logic                       byp,
  input  logic [NCH*PIX_W-1:0]       raw,
  output logic [NCH*PIX_W-1:0]       dout
);
  localparam int HALF = 1 << (FRAC_W - 1);

  logic [NCH-1:0][Y_W-1:0] y_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    int rnd;
    int yv;
    always_comb begin
      rnd = (int'($signed(sum[c])) + HALF) >>> FRAC_W;
      yv  = rnd + int'($signed(bias[c]));
    end

    always_ff @(posedge clk)
      if (en) y_q[c] <= yv[Y_W-1:0];
  end

  logic byp_q;
  logic [NCH*PIX_W-1:0] raw_q;

  always_ff @(posedge clk) begin
    if (en) begin
      byp_q <= byp;
      raw_q <= raw;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      for (int c = 0; c < NCH; c++)
        dout[c * PIX_W +: PIX_W] <= byp_q ? raw_q[c * PIX_W +: PIX_W]
                                          : clamp_win(int'($signed(y_q[c])), lo[c], hi[c]);
    end
  end
endmodule

// File: rtl/csc10_top.sv
module csc10_top
  import csc10_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_wr,
  input  logic [CFG_AW-1:0]      cfg_addr,
  input  logic [31:0]            cfg_wdata,
  output logic [31:0]            cfg_rdata,
  input  logic                   frame_start,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [NCH*PIX_W-1:0]   in_pix,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [NCH*PIX_W-1:0]   out_pix
);
  csc_cfg_t act_cfg;
  logic     adv;
  logic     v1, v2, v3, v4;
  logic     byp1, byp2;
  logic [NCH*PIX_W-1:0] raw1, raw2;
  logic [NCH-1:0][PIX_W-1:0] pre_q;
  logic [NCH-1:0][SUM_W-1:0] sum_q;

  csc10_regs u_regs (
    .clk(clk), .rst(rst), .wr(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
    .frame_start(frame_start), .rdata(cfg_rdata), .cfg(act_cfg)
  );

  assign adv      = !(v4 && !out_ready);
  assign in_ready = adv;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0; v4 <= 1'b0;
    end else if (adv) begin
      v1 <= in_valid; v2 <= v1; v3 <= v2; v4 <= v3;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      byp1 <= !act_cfg.en; raw1 <= in_pix;
      byp2 <= byp1;        raw2 <= raw1;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_pre
    csc10_bias_clamp u_pre (
      .clk(clk), .en(adv),
      .din($signed({1'b0, in_pix[c * PIX_W +: PIX_W]})),
      .bias($signed(act_cfg.pre_bias[c])),
      .lo(act_cfg.pre_lo[c]), .hi(act_cfg.pre_hi[c]),
      .dout(pre_q[c])
    );
  end

  csc10_matrix u_mat (
    .clk(clk), .en(adv), .a(pre_q), .coef(act_cfg.coef), .sum_q(sum_q)
  );

  csc10_post u_post (
    .clk(clk), .en(adv), .sum(sum_q), .bias(act_cfg.post_bias),
    .lo(act_cfg.post_lo), .hi(act_cfg.post_hi),
    .byp(byp2), .raw(raw2), .dout(out_pix)
  );

  assign out_valid = v4;
endmodule

// File: rtl/csc10_checker.sv
module csc10_checker
  import csc10_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic [31:0]       cfg_rdata,
  input logic              frame_start,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [NCH*PIX_W-1:0] out_pix,
  input csc_cfg_t          act
);
  p_rst_idle_r11: assert property (@(posedge clk) rst |=> !out_valid);

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));

  p_stall_block_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  p_active_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(act));

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (cfg_addr[CFG_AW-1:2] >= (CFG_AW-2)'(NWORDS)) |=> (cfg_rdata == 32'h0));
endmodule

bind csc10_top csc10_checker u_chk (
  .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
  .frame_start(frame_start), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_pix(out_pix), .act(act_cfg)
);

// File: tb/csc10_top_bench.sv
module csc10_top_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 1'b0;
  logic [7:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic frame_start = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [29:0] in_pix = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [29:0] out_pix;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] sh_w [18];
  logic [31:0] act_w [18];

  always #5 clk = ~clk;

  csc10_top u_csc10_top (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .frame_start(frame_start), .in_valid(in_valid),
    .in_ready(in_ready), .in_pix(in_pix), .out_valid(out_valid),
    .out_ready(out_ready), .out_pix(out_pix)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mask_of(input int i);
    if (i == 0) return 32'h1;
    if (i >= 1 && i <= 4) return 32'h1FFF_1FFF;
    if (i == 5) return 32'h1FFF;
    if (i >= 6 && i <= 11) return 32'h03FF_03FF;
    return 32'h7FF;
  endfunction

  function automatic int sx(input logic [31:0] v, input int w);
    int t;
    t = int'(v & ((32'd1 << w) - 1));
    if (v[w-1]) t = t - (1 << w);
    return t;
  endfunction

  function automatic logic [29:0] model(input logic [29:0] p);
    int a [3];
    logic [29:0] o;
    if (!act_w[0][0]) return p;
    for (int c = 0; c < 3; c++) begin
      int x;
      x = int'(p[c*10 +: 10]) + sx(act_w[12+c], 11);
      if (x > int'(act_w[6+c][9:0])) x = int'(act_w[6+c][9:0]);
      if (x < int'(act_w[6+c][25:16])) x = int'(act_w[6+c][25:16]);
      a[c] = x;
    end
    for (int r = 0; r < 3; r++) begin
      int s;
      int y;
      s = 0;
      for (int j = 0; j < 3; j++) begin
        int k;
        k = r*3 + j;
        s = s + a[j] * sx(act_w[1 + k/2] >> ((k%2)*16), 13);
      end
      y = ((s + 256) >>> 9) + sx(act_w[15+r], 11);
      if (y > int'(act_w[9+r][9:0])) y = int'(act_w[9+r][9:0]);
      if (y < int'(act_w[9+r][25:16])) y = int'(act_w[9+r][25:16]);
      o[r*10 +: 10] = y[9:0];
    end
    return o;
  endfunction

  function automatic logic [29:0] gen(input int k);
    return {10'(k*211 + 5), 10'(k*97 + 300), 10'(k*53 + 7)};
  endfunction

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 8'(idx*4); cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    if (idx < 18) sh_w[idx] = d & mask_of(idx);
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = 8'(idx*4);
    @(negedge clk);
    #1 d = cfg_rdata;
  endtask

  task automatic pulse_frame();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    for (int i = 0; i < 18; i++) act_w[i] = sh_w[i];
  endtask

  task automatic one_pixel(input logic [29:0] p, input logic [29:0] exp, input string tag);
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    repeat (5) @(negedge clk);
    in_valid = 1'b1; in_pix = p;
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      #1 chk("R8 valid early", {31'b0, out_valid}, 32'h0);
      @(negedge clk);
    end
    #1 chk("R8 valid on time", {31'b0, out_valid}, 32'h1);
    chk(tag, {2'b0, out_pix}, {2'b0, exp});
  endtask

  task automatic run_stream(input int n, input int seed, input bit stall, input string tag);
    logic [29:0] exp_q [$];
    int sent = 0;
    int got = 0;
    int cyc = 0;
    while ((sent < n || got < n) && cyc < 4000) begin
      @(negedge clk);
      in_valid  = (sent < n) && (!stall || (cyc % 5 != 2));
      in_pix    = gen(sent + seed);
      out_ready = !stall || (cyc % 3 != 0);
      #1;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk({tag, " extra pixel R9"}, 32'h1, 32'h0);
        else chk(tag, {2'b0, out_pix}, {2'b0, exp_q.pop_front()});
        got++;
      end
      if (in_valid && in_ready) begin
        exp_q.push_back(model(in_pix));
        sent++;
      end
      cyc++;
    end
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    chk("R9 pixel count", 32'(got), 32'(n));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    repeat (3) @(negedge clk);
    chk("R11 idle in reset", {31'b0, out_valid}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 idle after reset", {31'b0, out_valid}, 32'h0);
    for (int i = 0; i < 18; i++) begin
      rd(i, d);
      chk("R1 reset word", d, sh_w[i]);
    end
  endtask

  task automatic t_defaults();
    one_pixel(30'h0, {10'd512, 10'd512, 10'd64}, "R1 black");
    one_pixel({10'd1023, 10'd1023, 10'd1023}, {10'd516, 10'd516, 10'd940}, "R1 R5 white clamps luma");
    run_stream(40, 3, 1'b0, "R4 default stream");
  endtask

  task automatic t_program();
    logic [31:0] d;
    wr(1, 32'h0000_0200);
    wr(2, 32'h0000_1F00);
    wr(3, 32'h0000_0200);
    wr(4, 32'h0000_0000);
    wr(5, 32'hFFFF_0100);
    wr(7, 32'h00C8_0258);
    wr(9, 32'h0000_03FF);
    wr(10, 32'h02BC_0064);
    wr(11, 32'h0000_03FF);
    wr(12, 32'h0000_079C);
    wr(15, 32'h0000_0064);
    wr(16, 32'h0000_0000);
    wr(17, 32'h0000_07FD);
    rd(5, d);
    chk("R2 field mask", d, 32'h0000_0100);
    rd(1, d);
    chk("R7 staging readback", d, 32'h0000_0200);
    one_pixel({10'd1023, 10'd1023, 10'd1023}, {10'd516, 10'd516, 10'd940}, "R7 old set kept");
    pulse_frame();
    one_pixel({10'd301, 10'd700, 10'd50}, {10'd148, 10'd700, 10'd0}, "R3 R5 saturate low");
    one_pixel({10'd100, 10'd100, 10'd600}, {10'd47, 10'd700, 10'd550}, "R2 R4 round");
    one_pixel({10'd101, 10'd100, 10'd600}, {10'd48, 10'd700, 10'd550}, "R4 half up positive");
    one_pixel({10'd101, 10'd100, 10'd0}, {10'd48, 10'd700, 10'd50}, "R4 half up negative");
    run_stream(60, 11, 1'b1, "R9 stalled stream");
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(18, 32'hFFFF_FFFF);
    wr(63, 32'hFFFF_FFFF);
    rd(18, d);
    chk("R10 unmapped read", d, 32'h0);
    rd(1, d);
    chk("R10 neighbour intact", d, 32'h0000_0200);
    pulse_frame();
    run_stream(10, 29, 1'b0, "R10 datapath intact");
  endtask

  task automatic t_bypass();
    wr(0, 32'h0);
    pulse_frame();
    one_pixel({10'd1023, 10'd5, 10'd777}, {10'd1023, 10'd5, 10'd777}, "R6 bypass");
    run_stream(30, 41, 1'b1, "R6 bypass stream");
  endtask

  initial begin
    for (int i = 0; i < 18; i++) begin
      sh_w[i] = 32'h0;
      act_w[i] = 32'h0;
    end
    sh_w[0] = 32'h1;          sh_w[1] = 32'h0102_0083;  sh_w[2] = 32'h1FB5_0032;
    sh_w[3] = 32'h00E1_1F6C;  sh_w[4] = 32'h1F45_00E1;  sh_w[5] = 32'h0000_1FDC;
    sh_w[6] = 32'h3FF;        sh_w[7] = 32'h3FF;        sh_w[8] = 32'h3FF;
    sh_w[9] = 32'h0040_03AC;  sh_w[10] = 32'h0040_03C0; sh_w[11] = 32'h0040_03C0;
    sh_w[15] = 32'h040;       sh_w[16] = 32'h200;       sh_w[17] = 32'h200;
    for (int i = 0; i < 18; i++) act_w[i] = sh_w[i];
    t_reset();
    t_defaults();
    t_program();
    t_unmapped();
    t_bypass();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule